// File: doc/BRIEF.md
# IDE Dual-Drive Timing Calculator

This block works out the timing configuration for one IDE channel that carries a master drive (drive 0) and a slave drive (drive 1). For each drive it takes a mode number, a transfer kind (PIO, multiword DMA or Ultra DMA) and a presence flag. Three further inputs apply to the whole channel:
- `sec_chan` selects the channel;
- `split_cap` says whether the controller variant has separate slave timing fields;
- the current register contents (`cur_tim`, `cur_sid`, `cur_udma`) carry the bits that a new setting must keep.

From these the block produces a new 16-bit channel timing word, a new 8-bit slave timing byte and a new 32-bit Ultra DMA control/timing word.

Two strobes drive it. A compute strobe (`calc_go`) loads the result worked out from the drive settings. A default strobe (`dflt_go`) loads the channel's reset-to-default values. The results are registered. A small state machine records which result was loaded and raises `done` for one cycle. It has three states:
- `ST_IDLE`: no result loaded in the previous cycle.
- `ST_CALC_OUT`: a computed result was loaded.
- `ST_DFLT_OUT`: a default result was loaded.

Transitions are taken from any state on every clock edge, in this priority: `dflt_go` leads to `ST_DFLT_OUT`, otherwise `calc_go` leads to `ST_CALC_OUT`, otherwise the machine goes to `ST_IDLE`.

Top module: `ide_tim_calc`

## Requirements
- R1: One clock edge after either strobe, the outputs hold the new result and `done` is 1 for exactly that cycle. In a cycle after an edge with no strobe, `done` is 0 and all three outputs keep their values.
- R2: When `dflt_go` is high, it takes priority over `calc_go`. The default result is:
  - timing word: `cur_tim & 16'h8000`;
  - slave byte: `cur_sid`, unchanged;
  - Ultra DMA word, primary channel (`sec_chan`=0): `cur_udma & 32'hFFCCFFFC`;
  - Ultra DMA word, secondary channel: `cur_udma & 32'hCCFFFFF3`.
- R3: Each drive maps to a timing level L. The sample field is L and the recovery field is 0 for L=0, or L+1 otherwise. The cycle length in clocks is 9 − sample − recovery. The level is chosen as follows:
  - kind 0 = PIO: modes 0–2 give L=0, mode 3 gives L=1, modes 4 and above give L=2.
  - kind 1 = multiword DMA: modes 0 and 1 give L equal to the mode, modes 2 and above give L=2.
  - kind 2 = Ultra DMA: always L=2.
  - kind 3 is handled like kind 1.
  Without split timing, the computed word carries drive 0's sample field in bits 13:12 and its recovery field in bits 9:8.
- R4: Bit 14 of the computed word (split enable) is 1 only when all three hold: `split_cap`=1, the slave is present, and the two cycle lengths differ.
- R5: When `split_cap`=0, the slave is present and the cycle lengths differ, bits 13:12 hold the larger of the two sample fields and bits 9:8 hold the larger of the two recovery fields.
- R6: The computed word copies bit 15 from `cur_tim`. Bits 11:10 are 0.
- R7: With drive 0 present, bits 2:0 of the computed word are 1. Bits 6:4 are 1 only if the slave is also present.
- R8: Bit 3 is 1 when drive 0 is present and its kind is not PIO. Bit 7 is 1 when both drives are present and the slave's kind is not PIO.
- R9: The computed Ultra DMA word is `cur_udma` with the channel's two enable bits cleared: bits 1:0 on the primary channel, bits 3:2 on the secondary. Then, for each present drive of kind 2, taking the slave only when drive 0 is present:
  - the drive's enable bit is set (primary: master bit 0, slave bit 1; secondary: master bit 2, slave bit 3);
  - its 2-bit cycle field is set to min(mode, 2) (primary: master bits 17:16, slave bits 21:20; secondary: master bits 25:24, slave bits 29:28).
- R10: When drive 0 is absent, bits 13:0 of the computed word are 0 and no Ultra DMA enable is set.
- R11: When bit 14 is set and drive 0 is present, the slave's {sample, recovery} nibble is written into `sid_q` bits 3:0 (primary) or 7:4 (secondary). All other bits of `sid_q` equal `cur_sid`.
- R12: After reset, `tim_q`, `sid_q` and `udma_q` are 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| calc_go | input | 1 | Compute strobe |
| dflt_go | input | 1 | Reset-to-default strobe, takes priority over `calc_go` |
| sec_chan | input | 1 | 0 = primary channel, 1 = secondary channel |
| split_cap | input | 1 | Controller has separate slave timing fields |
| m_mode | input | 3 | Master drive mode number |
| m_kind | input | 2 | Master transfer kind (0 PIO, 1 MW DMA, 2 Ultra DMA) |
| m_here | input | 1 | Master drive present |
| s_mode | input | 3 | Slave drive mode number |
| s_kind | input | 2 | Slave transfer kind |
| s_here | input | 1 | Slave drive present |
| cur_tim | input | 16 | Current channel timing word |
| cur_sid | input | 8 | Current slave timing byte |
| cur_udma | input | 32 | Current Ultra DMA control/timing word |
| tim_q | output | 16 | New channel timing word |
| sid_q | output | 8 | New slave timing byte |
| udma_q | output | 32 | New Ultra DMA word |
| done | output | 1 | One-cycle pulse when a new result is loaded |

## Verification
Two functions can fall in the same cycle: a compute request and a reset-to-default request. The bench raises both strobes on the same clock edge, on each channel, with drive settings that would give a non-trivial computed result. It then judges the outcome against the default values: only bit 15 may remain in the timing word, and the channel's Ultra DMA bits must be masked off. The slave byte is checked as well, because a leaked computation could alter it. The same collision is also checked cycle by cycle by the bound assertions.

// File: rtl/ide_tim_pkg.sv
package ide_tim_pkg;
    localparam int MODE_W = 3;
    localparam int KIND_W = 2;
    localparam int TW     = 16;
    localparam int SW     = 8;
    localparam int UW     = 32;
    localparam int FLD_W  = 2;
    localparam int CYC_W  = 4;
    localparam int NDRV   = 2;
    localparam int SUB_W  = SW / NDRV;

    // timing word bit positions
    localparam int B_CHEN  = 15;
    localparam int B_SPLIT = 14;
    localparam int B_ISP   = 12;
    localparam int B_RCT   = 8;
    localparam int B_DRV1  = 4;
    localparam int B_DTE   = 3;

    // ultra dma word layout
    localparam int EN_PRI   = 0;
    localparam int EN_SEC   = 2;
    localparam int FLD_PRI  = 16;
    localparam int FLD_SEC  = 24;
    localparam int FLD_STEP = 4;

    localparam logic [TW-1:0] TIM_KEEP_DFLT = TW'(1) << B_CHEN;
    localparam logic [UW-1:0] UDMA_KEEP_PRI = 32'hFFCC_FFFC;
    localparam logic [UW-1:0] UDMA_KEEP_SEC = 32'hCCFF_FFF3;

    typedef enum logic [KIND_W-1:0] {
        XF_PIO   = 2'd0,
        XF_MWDMA = 2'd1,
        XF_UDMA  = 2'd2,
        XF_RSV   = 2'd3
    } xfer_e;

    typedef struct packed {
        logic [FLD_W-1:0] isp;
        logic [FLD_W-1:0] rct;
    } tpair_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [KIND_W-1:0] kind;
        logic              here;
    } drive_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CALC_OUT = 2'd1,
        ST_DFLT_OUT = 2'd2
    } st_e;

    function automatic logic [FLD_W-1:0] udma_clamp(input logic [MODE_W-1:0] m);
        return (m > MODE_W'(2)) ? FLD_W'(2) : m[FLD_W-1:0];
    endfunction

    function automatic logic [FLD_W-1:0] fmax(input logic [FLD_W-1:0] a,
                                              input logic [FLD_W-1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ide_mode_lut.sv
module ide_mode_lut
    import ide_tim_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [KIND_W-1:0] kind,
    output tpair_t            tp,
    output logic [CYC_W-1:0]  cyc
);
    logic [1:0] level;

    always_comb begin
        unique case (kind)
            XF_PIO: begin
                if (mode >= MODE_W'(4))      level = 2'd2;
                else if (mode == MODE_W'(3)) level = 2'd1;
                else                         level = 2'd0;
            end
            XF_UDMA: level = 2'd2;
            default: begin
                if (mode >= MODE_W'(2)) level = 2'd2;
                else                    level = mode[1:0];
            end
        endcase
        tp.isp = level;
        tp.rct = (level == 2'd0) ? 2'd0 : level + 2'd1;
        cyc    = CYC_W'(9) - CYC_W'(tp.isp) - CYC_W'(tp.rct);
    end
endmodule

// File: rtl/ide_tim_merge.sv
module ide_tim_merge
    import ide_tim_pkg::*;
(
    input  logic             sec,
    input  logic             split_cap,
    input  drive_t           d0,
    input  drive_t           d1,
    input  tpair_t           t0,
    input  tpair_t           t1,
    input  logic [CYC_W-1:0] c0,
    input  logic [CYC_W-1:0] c1,
    input  logic [TW-1:0]    cur_tim,
    input  logic [SW-1:0]    cur_sid,
    input  logic [UW-1:0]    cur_udma,
    output logic [TW-1:0]    tim,
    output logic [SW-1:0]    sid,
    output logic [UW-1:0]    udma
);
    logic   split, sitre;
    tpair_t pick;
    int     enb, fb;

    always_comb begin
        split = (c0 != c1) && d1.here;
        sitre = split && split_cap;
        if (split && !split_cap) begin
            pick.isp = fmax(t0.isp, t1.isp);
            pick.rct = fmax(t0.rct, t1.rct);
        end else begin
            pick = t0;
        end

        enb = sec ? EN_SEC : EN_PRI;
        fb  = sec ? FLD_SEC : FLD_PRI;

        tim          = '0;
        tim[B_CHEN]  = cur_tim[B_CHEN];
        tim[B_SPLIT] = sitre;
        sid          = cur_sid;
        udma         = cur_udma;
        udma[enb]    = 1'b0;
        udma[enb+1]  = 1'b0;

        if (d0.here) begin
            tim[B_ISP +: FLD_W] = pick.isp;
            tim[B_RCT +: FLD_W] = pick.rct;
            tim[B_DTE-1:0]      = 3'b111;
            tim[B_DTE]          = (d0.kind != XF_PIO);
            if (d0.kind == XF_UDMA) begin
                udma[enb]          = 1'b1;
                udma[fb +: FLD_W]  = udma_clamp(d0.mode);
            end
            if (d1.here) begin
                tim[B_DRV1 +: 3]    = 3'b111;
                tim[B_DRV1 + B_DTE] = (d1.kind != XF_PIO);
                if (d1.kind == XF_UDMA) begin
                    udma[enb+1]                  = 1'b1;
                    udma[fb + FLD_STEP +: FLD_W] = udma_clamp(d1.mode);
                end
            end
            if (sitre) begin
                if (sec) sid[SW-1:SUB_W]  = t1;
                else     sid[SUB_W-1:0]   = t1;
            end
        end
    end
endmodule

// File: rtl/ide_tim_dflt.sv
module ide_tim_dflt
    import ide_tim_pkg::*;
(
    input  logic          sec,
    input  logic [TW-1:0] cur_tim,
    input  logic [SW-1:0] cur_sid,
    input  logic [UW-1:0] cur_udma,
    output logic [TW-1:0] tim,
    output logic [SW-1:0] sid,
    output logic [UW-1:0] udma
);
    always_comb begin
        tim  = cur_tim & TIM_KEEP_DFLT;
        sid  = cur_sid;
        udma = cur_udma & (sec ? UDMA_KEEP_SEC : UDMA_KEEP_PRI);
    end
endmodule

// File: rtl/ide_tim_calc.sv
module ide_tim_calc
    import ide_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              calc_go,
    input  logic              dflt_go,
    input  logic              sec_chan,
    input  logic              split_cap,
    input  logic [MODE_W-1:0] m_mode,
    input  logic [KIND_W-1:0] m_kind,
    input  logic              m_here,
    input  logic [MODE_W-1:0] s_mode,
    input  logic [KIND_W-1:0] s_kind,
    input  logic              s_here,
    input  logic [TW-1:0]     cur_tim,
    input  logic [SW-1:0]     cur_sid,
    input  logic [UW-1:0]     cur_udma,
    output logic [TW-1:0]     tim_q,
    output logic [SW-1:0]     sid_q,
    output logic [UW-1:0]     udma_q,
    output logic              done
);
    drive_t           drv [NDRV];
    tpair_t           tp  [NDRV];
    logic [CYC_W-1:0] cyc [NDRV];

    assign drv[0] = '{mode: m_mode, kind: m_kind, here: m_here};
    assign drv[1] = '{mode: s_mode, kind: s_kind, here: s_here};

    for (genvar g = 0; g < NDRV; g++) begin : g_lut
        ide_mode_lut u_lut (
            .mode (drv[g].mode),
            .kind (drv[g].kind),
            .tp   (tp[g]),
            .cyc  (cyc[g])
        );
    end

    logic [TW-1:0] calc_tim, dflt_tim;
    logic [SW-1:0] calc_sid, dflt_sid;
    logic [UW-1:0] calc_udma, dflt_udma;

    ide_tim_merge u_merge (
        .sec       (sec_chan),
        .split_cap (split_cap),
        .d0        (drv[0]),
        .d1        (drv[1]),
        .t0        (tp[0]),
        .t1        (tp[1]),
        .c0        (cyc[0]),
        .c1        (cyc[1]),
        .cur_tim   (cur_tim),
        .cur_sid   (cur_sid),
        .cur_udma  (cur_udma),
        .tim       (calc_tim),
        .sid       (calc_sid),
        .udma      (calc_udma)
    );

    ide_tim_dflt u_dflt (
        .sec      (sec_chan),
        .cur_tim  (cur_tim),
        .cur_sid  (cur_sid),
        .cur_udma (cur_udma),
        .tim      (dflt_tim),
        .sid      (dflt_sid),
        .udma     (dflt_udma)
    );

    st_e state, nxt;

    always_comb begin
        if (dflt_go)      nxt = ST_DFLT_OUT;
        else if (calc_go) nxt = ST_CALC_OUT;
        else              nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q  <= '0;
            sid_q  <= '0;
            udma_q <= '0;
        end else begin
            unique case (nxt)
                ST_DFLT_OUT: begin
                    tim_q  <= dflt_tim;
                    sid_q  <= dflt_sid;
                    udma_q <= dflt_udma;
                end
                ST_CALC_OUT: begin
                    tim_q  <= calc_tim;
                    sid_q  <= calc_sid;
                    udma_q <= calc_udma;
                end
                default: begin
                    tim_q  <= tim_q;
                    sid_q  <= sid_q;
                    udma_q <= udma_q;
                end
            endcase
        end
    end

    assign done = (state != ST_IDLE);
endmodule

// File: rtl/ide_tim_calc_chk.sv
module ide_tim_calc_chk
    import ide_tim_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          calc_go,
    input logic          dflt_go,
    input logic          split_cap,
    input logic          m_here,
    input logic [TW-1:0] cur_tim,
    input logic [SW-1:0] cur_sid,
    input logic [TW-1:0] tim_q,
    input logic [SW-1:0] sid_q,
    input logic [UW-1:0] udma_q,
    input logic          done
);
    a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_go || dflt_go) |=> done);

    a_r1_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(calc_go || dflt_go) |=> (!done && $stable(tim_q) && $stable(sid_q) && $stable(udma_q)));

    a_r2_dflt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_go |=> (tim_q[B_SPLIT:0] == '0 && sid_q == $past(cur_sid)));

    a_r6_chen_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tim_q[B_CHEN] == $past(cur_tim[B_CHEN]));

    a_r4_no_split: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_go && !dflt_go && !split_cap) |=> !tim_q[B_SPLIT]);

    a_r7_master_en: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_go && !dflt_go) |=> tim_q[0] == $past(m_here));
endmodule

bind ide_tim_calc ide_tim_calc_chk u_chk (.*);

// File: tb/test_ide_tim_calc.sv
`timescale 1ns/1ps
module test_ide_tim_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        calc_go = 1'b0, dflt_go = 1'b0;
    logic        sec_chan = 1'b0, split_cap = 1'b0;
    logic [2:0]  m_mode = '0, s_mode = '0;
    logic [1:0]  m_kind = '0, s_kind = '0;
    logic        m_here = 1'b0, s_here = 1'b0;
    logic [15:0] cur_tim = '0;
    logic [7:0]  cur_sid = '0;
    logic [31:0] cur_udma = '0;
    logic [15:0] tim_q;
    logic [7:0]  sid_q;
    logic [31:0] udma_q;
    logic        done;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    ide_tim_calc i_ide_tim_calc (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void lvl(input logic [2:0] mode, input logic [1:0] kind,
                                output int isp, output int rct, output int cyc);
        int l;
        if (kind == 2'd0)      l = (mode < 3) ? 0 : (mode == 3) ? 1 : 2;
        else if (kind == 2'd2) l = 2;
        else                   l = (mode >= 2) ? 2 : int'(mode);
        isp = l;
        rct = (l == 0) ? 0 : l + 1;
        cyc = 9 - isp - rct;
    endfunction

    task automatic run_calc(input bit hold_chk);
        int i0, r0, c0, i1, r1, c1, ei, er;
        logic sp, st;
        logic [15:0] et;
        logic [7:0]  es;
        logic [31:0] eu;
        int eb, fb;
        cur_tim  = 16'($urandom);
        cur_sid  = 8'($urandom);
        cur_udma = $urandom;
        calc_go  = 1'b1;
        @(negedge clk);
        calc_go  = 1'b0;
        lvl(m_mode, m_kind, i0, r0, c0);
        lvl(s_mode, s_kind, i1, r1, c1);
        sp = (c0 != c1) && s_here;
        st = sp && split_cap;
        ei = (sp && !split_cap) ? ((i0 > i1) ? i0 : i1) : i0;
        er = (sp && !split_cap) ? ((r0 > r1) ? r0 : r1) : r0;
        et = '0;
        et[15] = cur_tim[15];
        et[14] = st;
        es = cur_sid;
        eb = sec_chan ? 2 : 0;
        fb = sec_chan ? 24 : 16;
        eu = cur_udma & ~(32'h3 << eb);
        if (m_here) begin
            et[13:12] = 2'(ei);
            et[9:8]   = 2'(er);
            et[2:0]   = 3'b111;
            et[3]     = (m_kind != 0);
            if (m_kind == 2) begin
                eu[eb] = 1'b1;
                eu[fb +: 2] = (m_mode > 2) ? 2'd2 : m_mode[1:0];
            end
            if (s_here) begin
                et[6:4] = 3'b111;
                et[7]   = (s_kind != 0);
                if (s_kind == 2) begin
                    eu[eb+1] = 1'b1;
                    eu[fb+4 +: 2] = (s_mode > 2) ? 2'd2 : s_mode[1:0];
                end
            end
            if (st) begin
                if (sec_chan) es[7:4] = {2'(i1), 2'(r1)};
                else          es[3:0] = {2'(i1), 2'(r1)};
            end
        end
        chk("R1 done pulse", 32'(done), 32'd1);
        chk("R4 split enable", 32'(tim_q[14]), 32'(et[14]));
        chk("R6 kept/cleared bits", 32'({tim_q[15], tim_q[11:10]}), 32'({et[15], 2'b00}));
        if (sp && !split_cap)
            chk("R5 slower-of-two fields", 32'({tim_q[13:12], tim_q[9:8]}), 32'({et[13:12], et[9:8]}));
        else
            chk("R3 master fields", 32'({tim_q[13:12], tim_q[9:8]}), 32'({et[13:12], et[9:8]}));
        chk("R7 drive enables", 32'({tim_q[6:4], tim_q[2:0]}), 32'({et[6:4], et[2:0]}));
        chk("R8 dma-only bits", 32'({tim_q[7], tim_q[3]}), 32'({et[7], et[3]}));
        chk("R9 ultra dma word", udma_q, eu);
        chk("R11 slave byte", 32'(sid_q), 32'(es));
        if (!m_here) chk("R10 master absent", 32'(tim_q[13:0]), 32'd0);
        if (hold_chk) begin
            cur_tim = ~cur_tim;
            cur_udma = ~cur_udma;
            @(negedge clk);
            chk("R1 idle done", 32'(done), 32'd0);
            chk("R1 idle hold", 32'(tim_q), 32'(et));
            chk("R1 idle hold udma", udma_q, eu);
        end
    endtask

    task automatic run_dflt(input bit sec, input bit with_calc);
        logic [31:0] eu;
        sec_chan  = sec;
        split_cap = 1'b1;
        m_here = 1'b1; m_kind = 2'd2; m_mode = 3'd4;
        s_here = 1'b1; s_kind = 2'd0; s_mode = 3'd0;
        cur_tim  = 16'hFFFF;
        cur_sid  = 8'h5A;
        cur_udma = 32'hFFFF_FFFF ^ 32'h0400_0040;
        eu = cur_udma & (sec ? 32'hCCFF_FFF3 : 32'hFFCC_FFFC);
        dflt_go = 1'b1;
        calc_go = with_calc;
        @(negedge clk);
        dflt_go = 1'b0;
        calc_go = 1'b0;
        chk("R2 done", 32'(done), 32'd1);
        chk("R2 default timing word", 32'(tim_q), 32'h8000);
        chk("R2 default udma", udma_q, eu);
        chk("R2 default slave byte", 32'(sid_q), 32'h5A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset tim", 32'(tim_q), 32'd0);
        chk("R12 reset sid", 32'(sid_q), 32'd0);
        chk("R12 reset udma", udma_q, 32'd0);
        chk("R12 reset done", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 done low after reset", 32'(done), 32'd0);
        for (int cap = 0; cap < 2; cap++)
            for (int sc = 0; sc < 2; sc++)
                for (int mh = 0; mh < 2; mh++)
                    for (int sh = 0; sh < 2; sh++)
                        for (int mm = 0; mm < 6; mm++)
                            for (int mk = 0; mk < 3; mk++)
                                for (int sm = 0; sm < 6; sm++)
                                    for (int sk = 0; sk < 3; sk++) begin
                                        split_cap = cap[0];
                                        sec_chan  = sc[0];
                                        m_here = mh[0]; s_here = sh[0];
                                        m_mode = 3'(mm); m_kind = 2'(mk);
                                        s_mode = 3'(sm); s_kind = 2'(sk);
                                        run_calc((sm + mm) % 5 == 0);
                                    end
        // kind 3 behaves as multiword dma
        split_cap = 1'b1; sec_chan = 1'b0; m_here = 1'b1; s_here = 1'b1;
        m_mode = 3'd7; m_kind = 2'd3; s_mode = 3'd1; s_kind = 2'd3;
        run_calc(1'b1);
        for (int sc = 0; sc < 2; sc++) begin
            run_dflt(sc[0], 1'b0);
            run_dflt(sc[0], 1'b1);
        end
        @(negedge clk);
        chk("R1 done after defaults", 32'(done), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule